// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits after a transport-stream decoder and puts the decoded bytes on an output port. Bytes come in on a valid/ready handshake. A start-of-packet marker and a per-packet error flag come with them. The flag is only sampled together with the start-of-packet byte. A packet is 188 bytes long and opens with the sync value 0x47. The port runs in one of two modes:

- **Parallel:** one byte per enabled cycle.
- **Serial:** one bit per enabled cycle, most significant bit first.

The block drives four qualifiers next to the data: a data enable, a packet-sync marker, an uncorrectable-packet marker, and a single pad output-enable. The pad output-enable is low after reset and is set from a register.

Packets flagged as uncorrectable pass through unchanged, with one optional exception. The transport error bit (bit 7 of the byte after the sync byte) can be forced to 1. This happens only while two separate disable bits are both low.

The configuration bits are taken only with a start-of-packet byte:
- the port mode,
- the serial sync width,
- the two disable bits.

So a packet never changes format halfway through.

Top module: `ts_stream_fmt`

## Requirements
- R1: While `rst_n` is low, and for the two clock edges after it rises, `out_oe`, `out_en`, `out_sync` and `out_uncor` are low and `in_ready` is low.
- R2: Once out of reset, `out_oe` equals the value `cfg_oe` had at the previous clock edge.
- R3: In parallel mode `in_ready` is high. A byte accepted at an edge is shown on `out_data` with `out_en` high for exactly the cycle after that edge.
- R4: In parallel mode `out_sync` is high only in the output cycle of a start-of-packet byte whose value is 0x47. A start-of-packet byte of any other value is still forwarded, with `out_sync` low.
- R5: In serial mode an accepted byte is shown on `out_data[0]` over the 8 cycles after the accept edge, bit 7 first. During those cycles `out_en` is high and `out_data[7:1]` is zero. `in_ready` is high only when no bits of an earlier byte are still pending.
- R6: In serial mode, for a start-of-packet byte of value 0x47, `out_sync` marks only its first bit when `cfg_sync_full` = 0, and all 8 of its bits when `cfg_sync_full` = 1.
- R7: `out_uncor` is high in every `out_en` cycle of a packet whose `in_err` was high with its start-of-packet byte. It is low in every `out_en` cycle of other packets.
- R8: Bit 7 of the byte accepted right after a start-of-packet byte is output as 1 when all of these hold at start of packet: the packet is flagged, `cfg_no_flag_a` = 0, and `cfg_no_flag_b` = 0. Every other byte, and every byte before the first start of packet, is output unchanged.
- R9: In a cycle with no symbol to show, `out_en`, `out_data`, `out_sync` and `out_uncor` are all zero. Input gaps do not shift the position count, so the R8 patch still lands on the byte after the start-of-packet byte.
- R10: `cfg_serial`, `cfg_sync_full`, `cfg_no_flag_a` and `cfg_no_flag_b` take effect only with an accepted start-of-packet byte. Changing them inside a packet does not alter the rest of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_oe | input | 1 | Pad output-enable request |
| cfg_serial | input | 1 | 1 = serial mode, 0 = parallel mode |
| cfg_sync_full | input | 1 | Serial sync marks all 8 bits of the sync byte when 1 |
| cfg_no_flag_a | input | 1 | First disable bit for error-bit insertion |
| cfg_no_flag_b | input | 1 | Second disable bit for error-bit insertion |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_err | input | 1 | Packet uncorrectable, sampled with `in_sop` |
| out_oe | output | 1 | Output-enable for all output pads |
| out_data | output | 8 | Output byte, or the serial bit in bit 0 |
| out_en | output | 1 | Output symbol valid |
| out_sync | output | 1 | Packet sync marker |
| out_uncor | output | 1 | Uncorrectable packet marker |

## Verification
The bench compares against a model that handles each pattern separately:

- **Back-to-back parallel packets** show that the output follows the input one byte per cycle.
- **Random input gaps, including a gap right after the sync byte**, separate a position count that only moves on accepted bytes from one that moves with time.
- **Flagged packets with insertion enabled, and with a disable bit set,** separate a correct header patch from a missing one or one applied too widely.
- **A packet whose first byte is not 0x47** separates sync that is decoded from the value from sync that only follows the marker.
- **Serial packets with each sync width** check the bit order, the width of the sync marker and the ready pacing.
- **Configuration changes in the middle of a packet** show whether options are taken only at packet start.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;
  localparam int            SYM_W    = 8;
  localparam int            PKT_BYTES = 188;
  localparam logic [7:0]    SYNC_VAL = 8'h47;

  typedef struct packed {
    logic serial;
    logic sync_full;
    logic err_ins;
  } fmt_cfg_t;
endpackage

// File: rtl/ts_pkt_track.sv
module ts_pkt_track
  import ts_fmt_pkg::*;
#(
  parameter int         BYTE_W = SYM_W,
  parameter int         PKT_LEN = PKT_BYTES,
  parameter logic [BYTE_W-1:0] SYNC_CODE = SYNC_VAL
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              sop_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              err_i,
  input  fmt_cfg_t          cfg_i,
  output fmt_cfg_t          cur_cfg_o,
  output fmt_cfg_t          eff_cfg_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              is_sync_o,
  output logic              err_o
);
  localparam int POS_W = $clog2(PKT_LEN);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  fmt_cfg_t         cfg_q, cfg_d;
  logic             err_q, err_d;
  logic             patch;

  always_comb begin
    eff_cfg_o = sop_i ? cfg_i : cfg_q;
    err_o     = sop_i ? err_i : err_q;
    patch     = !sop_i && (pos_q == '0) && err_o && eff_cfg_o.err_ins;
    byte_o    = data_i;
    byte_o[BYTE_W-1] = data_i[BYTE_W-1] | patch;
    is_sync_o = sop_i && (data_i == SYNC_CODE);
    cur_cfg_o = cfg_q;
  end

  always_comb begin
    pos_d = pos_q;
    cfg_d = cfg_q;
    err_d = err_q;
    if (acc_i) begin
      if (sop_i) begin
        pos_d = '0;
        cfg_d = cfg_i;
        err_d = err_i;
      end else if (pos_q != LAST_POS) begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= LAST_POS;
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  // R10: options only move with an accepted start-of-packet byte
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !(acc_i && sop_i) |=> $stable(cfg_q));

  // R8: only the byte right after the sync byte may differ from the input
  a_r8_patch_site: assert property (@(posedge clk) disable iff (!rst_ni)
    (byte_o != data_i) |-> (!sop_i && pos_q == '0 && err_o));
endmodule

// File: rtl/ts_par_stage.sv
module ts_par_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              sync_i,
  input  logic              err_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              en_o,
  output logic              sync_o,
  output logic              uncor_o
);
  logic [BYTE_W-1:0] data_q, data_d;
  logic              en_q, en_d, sync_q, sync_d, unc_q, unc_d;

  always_comb begin
    en_d   = load_i;
    data_d = load_i ? byte_i : '0;
    sync_d = load_i && sync_i;
    unc_d  = load_i && err_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      en_q   <= 1'b0;
      sync_q <= 1'b0;
      unc_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      en_q   <= en_d;
      sync_q <= sync_d;
      unc_q  <= unc_d;
    end
  end

  assign data_o  = data_q;
  assign en_o    = en_q;
  assign sync_o  = sync_q;
  assign uncor_o = unc_q;

  // R3: each parallel symbol lasts exactly one cycle unless reloaded
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_q && !load_i) |=> !en_q);
endmodule

// File: rtl/ts_ser_shift.sv
module ts_ser_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              sync_i,
  input  logic              full_i,
  input  logic              err_i,
  output logic              idle_o,
  output logic              bit_o,
  output logic              en_o,
  output logic              sync_o,
  output logic              uncor_o
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] REST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              hold_sync_q, hold_sync_d, err_q, err_d;
  logic              bit_q, bit_d, en_q, en_d, sync_q, sync_d, unc_q, unc_d;

  always_comb begin
    sh_d        = sh_q;
    rem_d       = rem_q;
    hold_sync_d = hold_sync_q;
    err_d       = err_q;
    bit_d       = 1'b0;
    en_d        = 1'b0;
    sync_d      = 1'b0;
    unc_d       = 1'b0;
    if (load_i) begin
      bit_d       = byte_i[BYTE_W-1];
      sh_d        = byte_i[BYTE_W-2:0];
      rem_d       = REST;
      hold_sync_d = sync_i && full_i;
      err_d       = err_i;
      en_d        = 1'b1;
      sync_d      = sync_i;
      unc_d       = err_i;
    end else if (rem_q != '0) begin
      bit_d  = sh_q[BYTE_W-2];
      sh_d   = {sh_q[BYTE_W-3:0], 1'b0};
      rem_d  = rem_q - 1'b1;
      en_d   = 1'b1;
      sync_d = hold_sync_q;
      unc_d  = err_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      rem_q       <= '0;
      hold_sync_q <= 1'b0;
      err_q       <= 1'b0;
      bit_q       <= 1'b0;
      en_q        <= 1'b0;
      sync_q      <= 1'b0;
      unc_q       <= 1'b0;
    end else begin
      sh_q        <= sh_d;
      rem_q       <= rem_d;
      hold_sync_q <= hold_sync_d;
      err_q       <= err_d;
      bit_q       <= bit_d;
      en_q        <= en_d;
      sync_q      <= sync_d;
      unc_q       <= unc_d;
    end
  end

  assign idle_o  = (rem_q == '0);
  assign bit_o   = bit_q;
  assign en_o    = en_q;
  assign sync_o  = sync_q;
  assign uncor_o = unc_q;

  // R5: a new byte is only loaded after the previous one is fully shifted
  a_r5_load_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |-> (rem_q == '0));

  // R5: bits of one byte come out in consecutive cycles
  a_r5_burst: assert property (@(posedge clk) disable iff (!rst_ni)
    (rem_q != '0) |=> en_q);
endmodule

// File: rtl/ts_stream_fmt.sv
module ts_stream_fmt
  import ts_fmt_pkg::*;
#(
  parameter int BYTE_W = SYM_W,
  parameter int PKT_LEN = PKT_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_oe,
  input  logic              cfg_serial,
  input  logic              cfg_sync_full,
  input  logic              cfg_no_flag_a,
  input  logic              cfg_no_flag_b,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_err,
  output logic              out_oe,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_en,
  output logic              out_sync,
  output logic              out_uncor
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_s_n;
  logic                  oe_q;
  fmt_cfg_t              live_cfg, cur_cfg, eff_cfg;
  logic                  acc, load_par, load_ser;
  logic [BYTE_W-1:0]     pkt_byte, par_data;
  logic                  pkt_sync, pkt_err;
  logic                  par_en, par_sync, par_unc;
  logic                  ser_idle, ser_bit, ser_en, ser_sync, ser_unc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[RST_STAGES-1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) oe_q <= 1'b0;
    else          oe_q <= cfg_oe;
  end

  always_comb begin
    live_cfg.serial    = cfg_serial;
    live_cfg.sync_full = cfg_sync_full;
    live_cfg.err_ins   = !cfg_no_flag_a && !cfg_no_flag_b;
    in_ready = rst_s_n && (cur_cfg.serial ? ser_idle : 1'b1);
    acc      = in_valid && in_ready;
    load_par = acc && !eff_cfg.serial;
    load_ser = acc && eff_cfg.serial;
  end

  ts_pkt_track #(.BYTE_W(BYTE_W), .PKT_LEN(PKT_LEN), .SYNC_CODE(BYTE_W'(SYNC_VAL))) u_track (
    .clk(clk), .rst_ni(rst_s_n), .acc_i(acc), .sop_i(in_sop), .data_i(in_data),
    .err_i(in_err), .cfg_i(live_cfg), .cur_cfg_o(cur_cfg), .eff_cfg_o(eff_cfg),
    .byte_o(pkt_byte), .is_sync_o(pkt_sync), .err_o(pkt_err)
  );

  ts_par_stage #(.BYTE_W(BYTE_W)) u_par (
    .clk(clk), .rst_ni(rst_s_n), .load_i(load_par), .byte_i(pkt_byte),
    .sync_i(pkt_sync), .err_i(pkt_err), .data_o(par_data), .en_o(par_en),
    .sync_o(par_sync), .uncor_o(par_unc)
  );

  ts_ser_shift #(.BYTE_W(BYTE_W)) u_ser (
    .clk(clk), .rst_ni(rst_s_n), .load_i(load_ser), .byte_i(pkt_byte),
    .sync_i(pkt_sync), .full_i(eff_cfg.sync_full), .err_i(pkt_err),
    .idle_o(ser_idle), .bit_o(ser_bit), .en_o(ser_en), .sync_o(ser_sync),
    .uncor_o(ser_unc)
  );

  assign out_oe    = oe_q;
  assign out_data  = par_data | {{(BYTE_W-1){1'b0}}, ser_bit};
  assign out_en    = par_en | ser_en;
  assign out_sync  = par_sync | ser_sync;
  assign out_uncor = par_unc | ser_unc;

  // R5: the two output stages never drive a symbol in the same cycle
  a_r5_one_stage: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(par_en && ser_en));

  // R9: an empty output cycle carries no data or markers
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    !out_en |-> (out_data == '0 && !out_sync && !out_uncor));

  // R2: pad enable follows the register request one edge later
  a_r2_oe_follow: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(rst_s_n) |-> (out_oe == $past(cfg_oe)));
endmodule

// File: tb/ts_stream_fmt_tb.sv
`timescale 1ns/100ps
module ts_stream_fmt_tb;
  logic       clk = 1'b0;
  logic       rst_n, cfg_oe, cfg_serial, cfg_sync_full, cfg_no_flag_a, cfg_no_flag_b;
  logic       in_valid, in_ready, in_sop, in_err;
  logic [7:0] in_data, out_data;
  logic       out_oe, out_en, out_sync, out_uncor;

  always #2.5 clk = ~clk;

  ts_stream_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_oe(cfg_oe), .cfg_serial(cfg_serial),
    .cfg_sync_full(cfg_sync_full), .cfg_no_flag_a(cfg_no_flag_a), .cfg_no_flag_b(cfg_no_flag_b),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop),
    .in_err(in_err), .out_oe(out_oe), .out_data(out_data), .out_en(out_en),
    .out_sync(out_sync), .out_uncor(out_uncor)
  );

  typedef struct {
    logic [7:0]  d;
    logic        s;
    logic        u;
    logic [31:0] dtag;
    logic [31:0] stag;
  } sym_t;

  sym_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   started = 0, done = 0;
  logic m_ser = 0, m_full = 0, m_ins = 0, m_err = 0;
  int   m_pos = 187;

  task automatic chk(input logic [31:0] tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] d, input logic sop,
                                          input logic err, input logic ins, input int pos);
    logic [7:0] b = d;
    if (!sop && pos == 0 && err && ins) b[7] = 1'b1;
    return b;
  endfunction

  task automatic push_byte(input logic [7:0] d, input logic sop, input logic e);
    logic ser  = sop ? cfg_serial : m_ser;
    logic full = sop ? cfg_sync_full : m_full;
    logic ins  = sop ? (!cfg_no_flag_a && !cfg_no_flag_b) : m_ins;
    logic err  = sop ? e : m_err;
    logic [7:0] b = exp_byte(d, sop, err, ins, m_pos);
    logic issync = sop && (d == 8'h47);
    logic differs = (cfg_serial != ser) || (cfg_sync_full != full) ||
                    ((!cfg_no_flag_a && !cfg_no_flag_b) != ins);
    logic [31:0] dtag = (!sop && m_pos == 0) ? "R8" : differs ? "R10" : ser ? "R5" : "R3";
    logic [31:0] stag = differs ? "R10" : ser ? "R6" : "R4";
    if (!ser) q.push_back('{b, issync, err, dtag, stag});
    else for (int i = 7; i >= 0; i--)
      q.push_back('{{7'b0, b[i]}, issync && (i == 7 || full), err, dtag, stag});
    if (sop) begin m_ser = ser; m_full = full; m_ins = ins; m_err = err; m_pos = 0; end
    else if (m_pos != 187) m_pos++;
  endtask

  task automatic check_out();
    sym_t x;
    if (out_en) begin
      if (q.size() == 0) chk("R9", 1, 0);
      else begin
        x = q.pop_front();
        chk(x.dtag, out_data, x.d);
        chk(x.stag, out_sync, x.s);
        chk("R7", out_uncor, x.u);
      end
    end else begin
      chk("R9", {out_data, out_sync, out_uncor}, 0);
    end
    if (started) begin
      chk(m_ser ? "R5" : "R3", in_ready, m_ser ? (q.size() == 0) : 1'b1);
      chk("R2", out_oe, cfg_oe);
    end
  endtask

  task automatic tick(input logic v, input logic [7:0] d, input logic s, input logic e,
                      output logic took);
    @(negedge clk);
    check_out();
    in_valid = v; in_data = d; in_sop = s; in_err = e;
    #1;
    took = v && in_ready;
    if (took) push_byte(d, s, e);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e, input int gap);
    logic took = 0;
    logic dummy;
    if (($urandom % 100) < gap) tick(0, 8'h00, 0, 0, dummy);
    while (!took) tick(1, d, s, e, took);
  endtask

  // flip: change live options mid-packet (R10)
  task automatic send_pkt(input int len, input logic [7:0] first, input logic e,
                          input int gap, input bit gap_after_sop, input bit flip);
    logic dummy;
    send_byte(first, 1, e, gap);
    if (gap_after_sop) repeat (3) tick(0, 8'h00, 0, 0, dummy);
    send_byte(8'h05, 0, 0, gap);
    for (int i = 2; i < len; i++) begin
      if (flip && i == len / 2) begin
        cfg_serial = ~cfg_serial; cfg_sync_full = ~cfg_sync_full; cfg_no_flag_a = ~cfg_no_flag_a;
      end
      send_byte(8'($urandom), 0, 0, gap);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, R1..R10 incomplete: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic dummy;
    int seed = 1234;
    void'($urandom(seed));
    rst_n = 0; cfg_oe = 0; cfg_serial = 0; cfg_sync_full = 0;
    cfg_no_flag_a = 0; cfg_no_flag_b = 0;
    in_valid = 0; in_data = 0; in_sop = 0; in_err = 0;
    repeat (3) tick(0, 8'h00, 0, 0, dummy);
    // R1: quiet outputs and no ready while in reset
    chk("R1", {out_oe, out_en, out_sync, out_uncor, in_ready}, 0);
    rst_n = 1;
    tick(0, 8'h00, 0, 0, dummy);
    chk("R1", {out_oe, out_en, in_ready}, 0);
    repeat (2) tick(0, 8'h00, 0, 0, dummy);
    started = 1;
    cfg_oe = 1;
    repeat (2) tick(0, 8'h00, 0, 0, dummy);
    chk("R2", out_oe, 1);

    send_pkt(188, 8'h47, 0, 0, 0, 0);          // R3 R4 back-to-back parallel
    send_pkt(188, 8'h47, 1, 30, 1, 0);         // R7 R8 R9 flagged, gaps
    cfg_no_flag_b = 1;
    send_pkt(188, 8'h47, 1, 20, 0, 0);         // R8 insertion disabled
    cfg_no_flag_b = 0;
    send_pkt(100, 8'h12, 0, 10, 0, 0);         // R4 bad sync value
    cfg_serial = 1; cfg_sync_full = 0;
    send_pkt(60, 8'h47, 1, 20, 1, 1);          // R5 R6 R10 serial, one-bit sync
    cfg_serial = 1; cfg_sync_full = 1; cfg_no_flag_a = 0;
    send_pkt(40, 8'h47, 0, 0, 0, 0);           // R6 full-byte sync
    cfg_serial = 0;
    send_pkt(120, 8'h47, 1, 15, 0, 1);         // R10 back to parallel, flip mid
    cfg_oe = 0;
    repeat (20) tick(0, 8'h00, 0, 0, dummy);
    chk("R9", q.size(), 0);
    chk("R2", out_oe, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule